// File: doc/BRIEF.md
# Sequential Shift-Subtract Integer Divider

This block divides an N-bit dividend by an N-bit divisor over several clock cycles. It uses one adder and one shift register that is roughly twice the operand width. The partial remainder sits in the upper part of that register and the dividend bits sit in the lower part. Quotient bits are shifted in at the bottom while the dividend bits move out at the top, so no separate quotient register is needed. The loop shifts first and then subtracts. A single right shift of the upper part at the end corrects the one extra shift that this order causes.

A one-cycle `start` pulse captures the operands and the signed/unsigned select. `busy` stays high while the block works. `done` pulses for one cycle when the quotient and the remainder become valid. Both results then hold until the next operation completes. A build-time option replaces the restore step with the nonrestoring variant. In that variant a negative partial remainder is carried forward and the divisor is added on the next step. Signed operands are divided as magnitudes, and the signs are applied afterwards.

Top module: `iter_div`

## Requirements
- R1: In unsigned mode (`sgn_mode`=0), when the divisor is not zero, `quot_o` is floor(dividend/divisor) and `rem_o` is dividend mod divisor.
- R2: When the divisor is not zero, `done` is high for exactly one cycle, WIDTH+1 clock edges after the edge that accepts `start`. `busy` is high for each cycle between the accepting edge and that edge, and low while `done` is high.
- R3: With NONRESTORING=1, the quotient, remainder, flag and timing are identical to those of the restoring build for every input.
- R4: In signed mode (`sgn_mode`=1), operands are read as two's complement. The quotient is rounded toward zero. The remainder takes the sign of the dividend, so -7/2 gives -3 with remainder -1. Both results are reduced to WIDTH bits, so the most negative value divided by -1 gives the most negative value with remainder 0.
- R5: A zero divisor sets `div_zero` and skips the iterations. `done` then comes one edge after the accepting edge, with `quot_o` all ones and `rem_o` equal to the dividend exactly as it was given.
- R6: A `start` pulse that arrives while `busy` is high has no effect. The running operation finishes with its own operands, and no new operation begins afterwards.
- R7: `quot_o`, `rem_o` and `div_zero` change only on the edge that raises `done`, and hold their values between completions.
- R8: After reset, `busy`, `done` and `div_zero` are 0, and `quot_o` and `rem_o` are 0.
- R9: Unsigned operands whose top bit is set divide correctly. The trial subtraction is wide enough that a large partial remainder still gives the correct sign, for example 15/1, 15/15 and 8/9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a division when idle |
| sgn_mode | input | 1 | 1 selects two's complement operands |
| dividend | input | WIDTH | Dividend |
| divisor | input | WIDTH | Divisor |
| quot_o | output | WIDTH | Quotient of the last completed division |
| rem_o | output | WIDTH | Remainder of the last completed division |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Division in progress |
| div_zero | output | 1 | Last completed division had a zero divisor |

## Verification
With a nonzero divisor, the results and `done` are due WIDTH+1 edges after the edge that samples `start`. With a zero divisor they are due one edge after it. The bench drives inputs on falling edges and counts falling edges from the accepting edge until `done` is seen. It checks that count against the expected latency, then compares the results at that same falling edge. One falling edge later it checks that `done` has dropped, that `busy` is still low after a `start` sent in the middle of the run, and that the results have not moved.

// File: rtl/div_pkg.sv
package div_pkg;
   typedef enum logic [1:0] {
      DS_IDLE = 2'd0,
      DS_RUN  = 2'd1,
      DS_FIX  = 2'd2
   } div_state_e;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] dvd_in,
   input  logic [WIDTH-1:0] dvs_in,
   input  logic             sgn,
   output logic [WIDTH-1:0] dvd_mag,
   output logic [WIDTH-1:0] dvs_mag,
   output logic             q_neg,
   output logic             r_neg
);
   logic dvd_is_neg, dvs_is_neg;

   always_comb begin
      dvd_is_neg = sgn & dvd_in[WIDTH-1];
      dvs_is_neg = sgn & dvs_in[WIDTH-1];
      dvd_mag    = dvd_is_neg ? (~dvd_in + 1'b1) : dvd_in;
      dvs_mag    = dvs_is_neg ? (~dvs_in + 1'b1) : dvs_in;
      q_neg      = dvd_is_neg ^ dvs_is_neg;
      r_neg      = dvd_is_neg;
   end
endmodule

// File: rtl/div_iter_step.sv
module div_iter_step #(
   parameter int WIDTH        = 32,
   parameter bit NONRESTORING = 1'b0
) (
   input  logic [2*WIDTH+1:0] acc_i,
   input  logic [WIDTH-1:0]   dvs,
   output logic [2*WIDTH+1:0] acc_o
);
   localparam int HW = WIDTH + 2;

   logic [HW-1:0]    hi, dext, trial, nxt_hi;
   logic [WIDTH-1:0] lo;
   logic             qbit;

   assign hi   = acc_i[2*WIDTH+1:WIDTH];
   assign lo   = acc_i[WIDTH-1:0];
   assign dext = {2'b00, dvs};

   generate
      if (NONRESTORING) begin : g_nonrest
         always_comb begin
            trial  = hi[HW-1] ? (hi + dext) : (hi - dext);
            qbit   = ~trial[HW-1];
            nxt_hi = trial;
         end
      end else begin : g_restore
         always_comb begin
            trial  = hi - dext;
            qbit   = ~trial[HW-1];
            nxt_hi = qbit ? trial : hi;
         end
      end
   endgenerate

   assign acc_o = {nxt_hi[HW-2:0], lo, qbit};
endmodule

// File: rtl/div_final_fix.sv
module div_final_fix #(
   parameter int WIDTH        = 32,
   parameter bit NONRESTORING = 1'b0
) (
   input  logic [2*WIDTH+1:0] acc,
   input  logic [WIDTH-1:0]   dvs,
   input  logic               q_neg,
   input  logic               r_neg,
   output logic [WIDTH-1:0]   quot,
   output logic [WIDTH-1:0]   rem
);
   localparam int HW = WIDTH + 2;

   logic [HW-1:0]    hi, shifted, corr;
   logic [WIDTH-1:0] q_mag, r_mag;

   assign hi      = acc[2*WIDTH+1:WIDTH];
   assign shifted = {hi[HW-1], hi[HW-1:1]};
   assign q_mag   = acc[WIDTH-1:0];

   generate
      if (NONRESTORING) begin : g_nonrest
         assign corr = shifted[HW-1] ? (shifted + {2'b00, dvs}) : shifted;
      end else begin : g_restore
         assign corr = shifted;
      end
   endgenerate

   assign r_mag = corr[WIDTH-1:0];
   assign quot  = q_neg ? (~q_mag + 1'b1) : q_mag;
   assign rem   = r_neg ? (~r_mag + 1'b1) : r_mag;
endmodule

// File: rtl/iter_div.sv
module iter_div
   import div_pkg::*;
#(
   parameter int WIDTH        = 32,
   parameter bit NONRESTORING = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             sgn_mode,
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic [WIDTH-1:0] quot_o,
   output logic [WIDTH-1:0] rem_o,
   output logic             done,
   output logic             busy,
   output logic             div_zero
);
   localparam int AW = 2 * WIDTH + 2;
   localparam int CW = $clog2(WIDTH + 1);
   localparam logic [CW-1:0] LAST_IT = CW'(WIDTH - 1);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("iter_div: WIDTH must be at least 2");
      end
   endgenerate

   div_state_e       state;
   logic [AW-1:0]    acc, acc_nxt;
   logic [WIDTH-1:0] dvs_q, dvd_raw_q;
   logic [WIDTH-1:0] dvd_mag, dvs_mag, q_fix, r_fix;
   logic             q_neg, r_neg, q_neg_q, r_neg_q, zero_q;
   logic [CW-1:0]    it_cnt;

   div_operand_prep #(.WIDTH(WIDTH)) u_prep (
      .dvd_in (dividend),
      .dvs_in (divisor),
      .sgn    (sgn_mode),
      .dvd_mag(dvd_mag),
      .dvs_mag(dvs_mag),
      .q_neg  (q_neg),
      .r_neg  (r_neg)
   );

   div_iter_step #(.WIDTH(WIDTH), .NONRESTORING(NONRESTORING)) u_step (
      .acc_i(acc),
      .dvs  (dvs_q),
      .acc_o(acc_nxt)
   );

   div_final_fix #(.WIDTH(WIDTH), .NONRESTORING(NONRESTORING)) u_fix (
      .acc  (acc),
      .dvs  (dvs_q),
      .q_neg(q_neg_q),
      .r_neg(r_neg_q),
      .quot (q_fix),
      .rem  (r_fix)
   );

   assign busy = (state != DS_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= DS_IDLE;
         acc       <= '0;
         dvs_q     <= '0;
         dvd_raw_q <= '0;
         q_neg_q   <= 1'b0;
         r_neg_q   <= 1'b0;
         zero_q    <= 1'b0;
         it_cnt    <= '0;
         quot_o    <= '0;
         rem_o     <= '0;
         done      <= 1'b0;
         div_zero  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            DS_IDLE: begin
               if (start) begin
                  acc       <= {{(WIDTH + 1){1'b0}}, dvd_mag, 1'b0};
                  dvs_q     <= dvs_mag;
                  dvd_raw_q <= dividend;
                  q_neg_q   <= q_neg;
                  r_neg_q   <= r_neg;
                  zero_q    <= (divisor == '0);
                  it_cnt    <= '0;
                  state     <= (divisor == '0) ? DS_FIX : DS_RUN;
               end
            end
            DS_RUN: begin
               acc    <= acc_nxt;
               it_cnt <= it_cnt + 1'b1;
               if (it_cnt == LAST_IT) state <= DS_FIX;
            end
            DS_FIX: begin
               state    <= DS_IDLE;
               done     <= 1'b1;
               div_zero <= zero_q;
               quot_o   <= zero_q ? '1 : q_fix;
               rem_o    <= zero_q ? dvd_raw_q : r_fix;
            end
            default: state <= DS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/iter_div_chk.sv
module iter_div_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         busy,
   input logic         done,
   input logic         div_zero,
   input logic [W-1:0] quot_o,
   input logic [W-1:0] rem_o
);
   localparam int CW = $clog2(W + 3);
   logic [CW-1:0] busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_len <= '0;
      else if (busy) busy_len <= busy_len + 1'b1;
      else           busy_len <= '0;
   end

   a_r2_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done && !div_zero |-> busy_len == CW'(W + 1));
   a_r5_zero_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done && div_zero |-> busy_len == CW'(1));
   a_r5_zero_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
      done && div_zero |-> quot_o == '1);
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(quot_o) || !$stable(rem_o) || !$stable(div_zero) |-> done);
endmodule

bind iter_div iter_div_chk #(.W(WIDTH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .done    (done),
   .div_zero(div_zero),
   .quot_o  (quot_o),
   .rem_o   (rem_o)
);

// File: tb/test_iter_div.sv
module test_iter_div;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         sgn_mode = 1'b0;
   logic [W-1:0] dividend = '0;
   logic [W-1:0] divisor = '0;
   logic [W-1:0] q_a, r_a, q_b, r_b;
   logic         done_a, busy_a, z_a, done_b, busy_b, z_b;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   iter_div #(.WIDTH(W), .NONRESTORING(1'b0)) i_iter_div (
      .clk(clk), .rst_n(rst_n), .start(start), .sgn_mode(sgn_mode),
      .dividend(dividend), .divisor(divisor),
      .quot_o(q_a), .rem_o(r_a), .done(done_a), .busy(busy_a), .div_zero(z_a)
   );

   iter_div #(.WIDTH(W), .NONRESTORING(1'b1)) i_iter_div_nr (
      .clk(clk), .rst_n(rst_n), .start(start), .sgn_mode(sgn_mode),
      .dividend(dividend), .divisor(divisor),
      .quot_o(q_b), .rem_o(r_b), .done(done_b), .busy(busy_b), .div_zero(z_b)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_op(input int a, input int b, input bit s, input bit glitch);
      int    eq, er, ez, elat, cyc;
      int    sa, sb;
      string req;
      if (b == 0) begin
         eq = 15; er = a; ez = 1; elat = 1; req = "R5";
      end else if (s) begin
         sa = (a >= 8) ? a - 16 : a;
         sb = (b >= 8) ? b - 16 : b;
         eq = (sa / sb) & 15; er = (sa % sb) & 15; ez = 0; elat = W + 1; req = "R4";
      end else begin
         eq = a / b; er = a % b; ez = 0; elat = W + 1;
         req = (a >= 8 || b >= 8) ? "R9" : "R1";
      end
      @(negedge clk);
      dividend = a[W-1:0]; divisor = b[W-1:0]; sgn_mode = s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!done_a) begin
         @(negedge clk);
         cyc++;
         if (glitch && cyc == 2) begin
            start = 1'b1; dividend = ~a[W-1:0]; divisor = 4'd1; sgn_mode = ~s;
         end
         if (glitch && cyc == 3) begin
            start = 1'b0; dividend = a[W-1:0]; divisor = b[W-1:0]; sgn_mode = s;
         end
      end
      chk("R2", "latency", cyc, elat);
      chk(req, "quotient", int'(q_a), eq);
      chk(req, "remainder", int'(r_a), er);
      chk(req, "zero flag", int'(z_a), ez);
      chk("R3", "nonrest done", int'(done_b), 1);
      chk("R3", "nonrest quotient", int'(q_b), eq);
      chk("R3", "nonrest remainder", int'(r_b), er);
      chk("R3", "nonrest zero flag", int'(z_b), ez);
      if (glitch) begin
         @(negedge clk);
         chk("R2", "done single pulse", int'(done_a), 0);
         chk("R6", "busy after ignored start", int'(busy_a), 0);
         repeat (2) @(negedge clk);
         chk("R6", "no restart", int'(busy_a), 0);
         chk("R7", "quotient held", int'(q_a), eq);
         chk("R7", "remainder held", int'(r_a), er);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R8", "reset busy", int'(busy_a), 0);
      chk("R8", "reset done", int'(done_a), 0);
      chk("R8", "reset zero flag", int'(z_a), 0);
      chk("R8", "reset quotient", int'(q_a), 0);
      chk("R8", "reset remainder", int'(r_a), 0);
      rst_n = 1'b1;
      run_op(14, 3, 1'b0, 1'b1);
      run_op(9, 14, 1'b1, 1'b1);
      run_op(8, 15, 1'b1, 1'b0);
      for (int s = 0; s < 2; s++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               run_op(a, b, s[0], (a == b) && (b != 0));
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule